// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a host request port to the pins of a four-bank synchronous DRAM. The host asks for one byte at a time, read or write. For each request the controller opens the row, waits out the row-to-column delay, and issues the column command. On a write the byte goes onto DQ in the same cycle as the write command. On a read the byte is taken from DQ once the programmed CAS latency has passed. The bank is then closed with a precharge.

A refresh timer raises a refresh request about every 15.6 µs. That rate gives 4096 refreshes in each 64 ms. A pending refresh is issued as soon as the controller is idle, and host requests are held off until it has finished. After reset the controller waits a power-up interval and precharges every bank. It then runs two refresh cycles and writes the mode register. All delays are given in nanoseconds and are converted to whole clock cycles, rounded up, using a clock-period parameter.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, the command pins carry NOP, `sd_cke` is low, `sd_dqm` is high, and both `req_ready` and `rd_valid` are low.
- R2: Initialisation follows this order:
  - The controller waits at least the power-up cycle count.
  - It issues a precharge with A10 high.
  - It issues two auto-refreshes.
  - It issues a mode-register write on bank 0. The address is A[2:0]=000 (single-beat burst), A3=0 (sequential) and A[6:4]=010 for `cl3`=0 or 011 for `cl3`=1; every other bit is 0.
  - Only after the mode-register write may the controller accept requests.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as follows, and no other code ever appears:
  - NOP 0111
  - activate 0011
  - read 0101
  - write 0100
  - precharge 0010
  - refresh 0001
  - mode write 0000
- R4: A read or write command follows its activate after exactly ceil(tRCD/period) cycles.
- R5: An activate comes at least ceil(tRP/period) cycles after the last precharge and at least ceil(tRFC/period) cycles after the last refresh.
- R6: In the cycle of a write command, `sd_dq_oe` is high and `sd_dq_out` holds the request byte. In every other cycle `sd_dq_oe` is low.
- R7: The read byte is taken from `sd_dq_in` CAS-latency cycles after the memory samples the read command. `rd_valid` pulses for a single cycle with that byte.
- R8: The gap between successive refreshes after initialisation never exceeds the refresh interval plus 32 cycles. `req_ready` stays low for the whole refresh recovery.
- R9: `req_addr` splits as {bank[22:21], row[20:9], column[8:0]}. The activate drives the row on A. The column command drives the column on A[8:0] with A10 low. The closing precharge has A10 low and goes to the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl3 | input | 1 | CAS latency select, taken at mode load: 1 gives 3, 0 gives 2 |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank, row, column} |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request is taken on a clock edge where valid and ready are both high |
| rd_valid | output | 1 | Read byte available (one cycle) |
| rd_data | output | 8 | Read byte |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 8 | Write data toward the pads |
| sd_dq_oe | output | 1 | Output enable for the write data |
| sd_dq_in | input | 8 | Read data from the pads |

## Verification
The refresh timer and host traffic collide. The bench shortens the refresh interval to 500 cycles and keeps requests arriving back to back, so a refresh request often comes due while a request is waiting or an access is in progress. A memory model on the pins judges each collision. It checks that no activate lands inside the refresh recovery, that `req_ready` stays low during it, and that the gap between refreshes stays bounded. Every byte read back must still equal the value computed from its address. The sweep covers all four banks and the first and last rows and columns, and it runs with CAS latency 2 and then 3.

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RFC_NS      = 70,
  parameter int T_REFI_NS     = 15625,
  parameter int POWERUP_NS    = 100000,
  parameter int WR_CYC        = 2,
  parameter int MRD_CYC       = 2,
  parameter int CNT_W         = 16,
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DATA_W        = 8,
  localparam int ADDR_W       = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl3,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int RCD_CYC  = (T_RCD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RP_CYC   = (T_RP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RFC_CYC  = (T_RFC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int PWR_CYC  = (POWERUP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int REFI_CYC = T_REFI_NS / CLK_PERIOD_NS;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;
  localparam logic [ROW_W-1:0] A10 = ROW_W'(1) << 10;

  typedef enum logic [3:0] {
    ST_PWR, ST_PALL, ST_IREF, ST_MRS, ST_IDLE,
    ST_ACT, ST_RD, ST_WR, ST_PRE, ST_REF
  } state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   ref_cnt;
  logic               ref_pend;
  logic               second;
  logic               cl_q;
  logic [3:0]         cmd;
  logic               rq_we;
  logic [COL_W-1:0]   rq_col;
  logic [DATA_W-1:0]  rq_wdata;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign req_ready = (st == ST_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PWR;
      cnt       <= CNT_W'(PWR_CYC - 1);
      ref_cnt   <= CNT_W'(REFI_CYC - 1);
      ref_pend  <= 1'b0;
      second    <= 1'b0;
      cl_q      <= 1'b0;
      cmd       <= C_NOP;
      sd_cke    <= 1'b0;
      sd_dqm    <= 1'b1;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rq_we     <= 1'b0;
      rq_col    <= '0;
      rq_wdata  <= '0;
    end else begin
      sd_cke   <= 1'b1;
      cmd      <= C_NOP;
      sd_dq_oe <= 1'b0;
      rd_valid <= 1'b0;
      if (ref_cnt == '0) begin
        ref_cnt  <= CNT_W'(REFI_CYC - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
      if (cnt != '0) cnt <= cnt - 1'b1;

      case (st)
        ST_PWR: if (cnt == '0) begin
          cmd <= C_PRE; sd_addr <= A10; st <= ST_PALL; cnt <= CNT_W'(RP_CYC - 1);
        end
        ST_PALL: if (cnt == '0) begin
          cmd <= C_REF; second <= 1'b0; st <= ST_IREF; cnt <= CNT_W'(RFC_CYC - 1);
        end
        ST_IREF: if (cnt == '0) begin
          if (!second) begin
            cmd <= C_REF; second <= 1'b1; cnt <= CNT_W'(RFC_CYC - 1);
          end else begin
            cmd     <= C_MRS;
            sd_ba   <= '0;
            sd_addr <= ROW_W'({2'b01, cl3, 4'b0000});
            cl_q    <= cl3;
            st      <= ST_MRS;
            cnt     <= CNT_W'(MRD_CYC - 1);
          end
        end
        ST_MRS: if (cnt == '0) begin
          sd_dqm <= 1'b0; st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd      <= C_REF;
            ref_pend <= (ref_cnt == '0);
            st       <= ST_REF;
            cnt      <= CNT_W'(RFC_CYC - 1);
          end else if (req_valid) begin
            cmd      <= C_ACT;
            sd_ba    <= req_addr[ADDR_W-1 -: BANK_W];
            sd_addr  <= req_addr[COL_W +: ROW_W];
            rq_we    <= req_we;
            rq_col   <= req_addr[COL_W-1:0];
            rq_wdata <= req_wdata;
            st       <= ST_ACT;
            cnt      <= CNT_W'(RCD_CYC - 1);
          end
        end
        ST_ACT: if (cnt == '0) begin
          sd_addr <= ROW_W'(rq_col);
          if (rq_we) begin
            cmd <= C_WR; sd_dq_oe <= 1'b1; sd_dq_out <= rq_wdata;
            st  <= ST_WR; cnt <= CNT_W'(WR_CYC - 1);
          end else begin
            cmd <= C_RD; st <= ST_RD; cnt <= cl_q ? CNT_W'(3) : CNT_W'(2);
          end
        end
        ST_RD: if (cnt == '0) begin
          rd_data <= sd_dq_in; rd_valid <= 1'b1;
          cmd <= C_PRE; sd_addr <= '0; st <= ST_PRE; cnt <= CNT_W'(RP_CYC - 1);
        end
        ST_WR: if (cnt == '0) begin
          cmd <= C_PRE; sd_addr <= '0; st <= ST_PRE; cnt <= CNT_W'(RP_CYC - 1);
        end
        ST_PRE, ST_REF: if (cnt == '0) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk #(
  parameter int RCD_CYC = 5,
  parameter int RP_CYC  = 5,
  parameter int RFC_CYC = 18,
  parameter int ROW_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             dq_oe,
  input logic             ready,
  input logic             rdv
);
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};
  logic is_act, is_rw, is_wr, is_pre, is_ref;
  assign is_act = (c == 4'b0011);
  assign is_wr  = (c == 4'b0100);
  assign is_rw  = (c == 4'b0101) || is_wr;
  assign is_pre = (c == 4'b0010);
  assign is_ref = (c == 4'b0001);

  logic [7:0] act_age, pre_age, ref_age;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_age <= 8'hff; pre_age <= 8'hff; ref_age <= 8'hff;
    end else begin
      act_age <= is_act ? 8'd1 : (act_age == 8'hff ? act_age : act_age + 8'd1);
      pre_age <= is_pre ? 8'd1 : (pre_age == 8'hff ? pre_age : pre_age + 8'd1);
      ref_age <= is_ref ? 8'd1 : (ref_age == 8'hff ? ref_age : ref_age + 8'd1);
    end
  end

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (int'(act_age) == RCD_CYC));
  p_act_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (int'(pre_age) >= RP_CYC) && (int'(ref_age) >= RFC_CYC));
  p_wdata_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == is_wr);
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdv |=> !rdv);
  p_ref_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> !ready);
  p_col_a10_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> !addr[10]);
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
  .RCD_CYC(RCD_CYC), .RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr), .dq_oe(sd_dq_oe),
  .ready(req_ready), .rdv(rd_valid)
);

// File: tb/sdram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdram_seq_ctrl_tb_top;
  localparam int RCD = 5, RP = 5, RFC = 18, PWR = 100, REFI = 500;

  logic clk = 1'b0, rst_n = 1'b0, cl3 = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [22:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic sd_dqm, sd_dq_oe;
  logic [7:0] rd_data, sd_dq_out;
  logic [7:0] sd_dq_in = 8'hEE;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  always #2 clk = ~clk;

  sdram_seq_ctrl #(.CLK_PERIOD_NS(4), .T_REFI_NS(2000), .POWERUP_NS(400)) dut_i (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int n_run = 0, n_fail = 0, pass_no = 0;
  int cyc, last_pre, last_ref, act_cyc, rd_due, init_refs, nref;
  bit pall_seen, init_done;
  logic [11:0] act_row;
  logic [1:0]  act_ba;
  logic [7:0]  rd_dat;
  logic [7:0]  mem [int];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int row, input int col);
    return 8'((b * 61 + row * 7 + col * 3 + pass_no * 17) & 255);
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    int key;
    cyc++;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    key = {sd_ba, act_row, sd_addr[8:0]};
    case (c)
      4'b0111: ;
      4'b0011: begin
        chk(cyc - last_pre >= RP, "R5 pre->act", cyc - last_pre, RP);
        chk(cyc - last_ref >= RFC, "R5 ref->act", cyc - last_ref, RFC);
        chk(init_done, "R2 act before init", 0, 1);
        act_cyc = cyc; act_row = sd_addr; act_ba = sd_ba;
      end
      4'b0100, 4'b0101: begin
        chk(cyc - act_cyc == RCD, "R4 act->col", cyc - act_cyc, RCD);
        chk(!sd_addr[10] && sd_ba == act_ba, "R9 col cmd", int'(sd_addr), 0);
        if (c == 4'b0100) begin
          chk(sd_dq_oe == 1'b1, "R6 oe", int'(sd_dq_oe), 1);
          chk(sd_dq_out == pat(sd_ba, act_row, sd_addr[8:0]), "R6 data",
              int'(sd_dq_out), int'(pat(sd_ba, act_row, sd_addr[8:0])));
          mem[key] = sd_dq_out;
        end else begin
          rd_due = cyc + (cl3 ? 3 : 2);
          rd_dat = mem.exists(key) ? mem[key] : 8'h00;
        end
      end
      4'b0010: begin
        if (!pall_seen) begin
          chk(cyc >= PWR && sd_addr[10], "R2 precharge all", cyc, PWR);
          pall_seen = 1;
        end else begin
          chk(!sd_addr[10] && sd_ba == act_ba, "R9 precharge", int'(sd_addr), 0);
        end
        last_pre = cyc;
      end
      4'b0001: begin
        if (init_done) begin
          if (nref > 0) chk(cyc - last_ref <= REFI + 32, "R8 refresh gap", cyc - last_ref, REFI + 32);
          nref++;
        end else begin
          chk(pall_seen && cyc - last_pre >= RP, "R2 init refresh", cyc - last_pre, RP);
          init_refs++;
        end
        last_ref = cyc;
      end
      4'b0000: begin
        chk(init_refs == 2 && sd_ba == 0, "R2 refresh count", init_refs, 2);
        chk(sd_addr == {5'b0, 2'b01, cl3, 4'b0}, "R2 mode", int'(sd_addr),
            int'({5'b0, 2'b01, cl3, 4'b0}));
        init_done = 1;
      end
      default: chk(0, "R3 illegal command", int'(c), 7);
    endcase
    if (cyc - last_ref < RFC && req_ready)
      chk(0, "R8 ready in refresh", 1, 0);
    sd_dq_in = (cyc == rd_due) ? rd_dat : 8'hEE;
  end

  task automatic do_reset(input bit c3);
    rst_n = 1'b0; cl3 = c3;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 nop",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk(!sd_cke && sd_dqm, "R1 cke/dqm", int'({sd_cke, sd_dqm}), 1);
    chk(!req_ready && !rd_valid, "R1 ready/valid", int'({req_ready, rd_valid}), 0);
    cyc = 0; last_pre = -1000; last_ref = -1000; act_cyc = -1000; rd_due = -1;
    init_refs = 0; nref = 0; pall_seen = 0; init_done = 0; mem.delete();
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    chk(init_done, "R2 ready after mode load", 0, 1);
  endtask

  task automatic do_req(input bit we, input int b, input int row, input int col);
    req_valid = 1'b1; req_we = we;
    req_addr = {2'(b), 12'(row), 9'(col)};
    req_wdata = pat(b, row, col);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!we) begin
      int t = 0;
      while (!rd_valid && t < 100) begin @(negedge clk); t++; end
      chk(rd_valid && rd_data == pat(b, row, col), "R7 read data",
          int'(rd_data), int'(pat(b, row, col)));
      @(negedge clk);
      chk(!rd_valid, "R7 single pulse", int'(rd_valid), 0);
    end
  endtask

  initial begin
    int rows[3] = '{0, 1, 4095};
    int cols[3] = '{0, 3, 511};
    for (int p = 0; p < 2; p++) begin
      pass_no = p;
      do_reset(p == 1);
      for (int w = 1; w >= 0; w--)
        for (int b = 0; b < 4; b++)
          for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
              do_req(w == 1, b, rows[i], cols[j]);
      chk(nref >= 2, "R8 refreshes issued", nref, 2);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++; n_run++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule